// File: doc/BRIEF.md
# Bridge Address Window Translator

This block sits behind one inbound aperture of a bridge and turns an aperture offset into an address in a peer partition's space. The bottom of the aperture is a table region made of equal 64 KiB pages. Each page has its own translation entry, which holds an enable flag, a partition number and a 64 KiB-aligned target base. Above the table region lies a single direct window. Its enable, power-of-two size and translate base are held in three control registers. The number of table pages is a power of two, so the direct window starts at a naturally aligned offset.

Configuration arrives over a simple write port: one strobe, a register kind, an entry index and a 64-bit data word. Lookups are presented one per cycle. Each lookup yields, one clock later, a response carrying hit or miss, the translated address and the target partition. A malformed direct-window size is refused. The refusal sets a sticky error flag and shuts the direct window.

Top module: `aperture_xlate`

## Requirements
- R1: After reset every table entry and the direct window are disabled and `cfg_err` is low, so every lookup misses.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `acc_valid` high and is low otherwise.
- R3: An offset below `LUT_N`×64 KiB selects table entry offset/64 KiB. An entry word is written with `cfg_kind` 0 at index `cfg_idx`, with bit 0 as the enable, bits [PART_W:1] as the partition and bits [OUT_W-1:16] as the target base. All other bits of the word are ignored.
- R4: A hit on an enabled table entry returns the entry base with the low 16 offset bits placed below it, together with the entry's partition.
- R5: A lookup that selects a disabled table entry misses.
- R6: The direct window starts at offset `LUT_N`×64 KiB. A lookup there hits when the window is enabled, holds an accepted size 2^L, and the distance d from the window start is below 2^L. The address is then the translate register with its low L bits replaced by the low L bits of d, and the partition is translate-register bits [PART_W-1:0]. The translate register is written with `cfg_kind` 3 from data bits [OUT_W-1:0].
- R7: The direct control register is written with `cfg_kind` 1, and data bit 0 is the window enable. While it is clear, direct lookups miss.
- R8: The size register is written with `cfg_kind` 2. A word equal to 2^L OR L, with L in bits [5:0], is accepted only when 12 ≤ L ≤ log2(`LUT_N`×64 KiB).
- R9: Any other nonzero size word is rejected. A rejection sets `cfg_err`, which stays set until reset, clears the enable and leaves no accepted size, so the window misses until a valid size and an enable are both written again.
- R10: A size word of zero clears the window's size without raising `cfg_err`, and direct lookups then miss.
- R11: An offset at or beyond the end of the direct window misses. Every miss returns address 0 and partition 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 0 table entry, 1 direct control, 2 direct size, 3 direct translate |
| cfg_idx | input | $clog2(LUT_N) | Table entry index for kind 0 |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_err | output | 1 | Sticky flag for a rejected size write |
| acc_valid | input | 1 | Lookup request |
| acc_offset | input | APER_W | Offset of the access inside the aperture |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | OUT_W | Translated address, zero on miss |
| rsp_part | output | PART_W | Target partition, zero on miss |

## Verification
The bench sweeps the whole aperture at 4 KiB steps, each step with a varying low part, so that every table page, the seam between the table region and the direct window, and the space past the window are all visited. The sweep runs after reset and with mixed enabled and disabled entries carrying junk in the ignored bits, which separates index selection from field decoding. It then runs for every legal direct size from 4 KiB up to the cap, so an error in the mask or the bound shows as a wrong address or a false hit near the window edge. Separate sequences issue zero, undersized, oversized and non-power-of-two size writes, and they check the error flag against whether the window still responds. This separates a clear from a rejection, and a rejection from a later re-enable.

// File: rtl/aperture_xlate_pkg.sv
package aperture_xlate_pkg;

  localparam int unsigned PAGE_LOG    = 16;
  localparam int unsigned DIR_MIN_LOG = 12;

  typedef enum logic [1:0] {
    CFG_LUT    = 2'd0,
    CFG_DCTRL  = 2'd1,
    CFG_DSIZE  = 2'd2,
    CFG_DXLATE = 2'd3
  } cfg_kind_e;

endpackage

// File: rtl/aperture_xlate_lut.sv
module aperture_xlate_lut
  import aperture_xlate_pkg::*;
#(
  parameter int unsigned LUT_N  = 4,
  parameter int unsigned OUT_W  = 40,
  parameter int unsigned PART_W = 3,
  localparam int unsigned IDX_W  = $clog2(LUT_N),
  localparam int unsigned BASE_W = OUT_W - PAGE_LOG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [63:0]         wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [PAGE_LOG-1:0] rd_page_off,
  output logic                rd_hit,
  output logic [OUT_W-1:0]    rd_addr,
  output logic [PART_W-1:0]   rd_part
);

  typedef struct packed {
    logic              en;
    logic [PART_W-1:0] part;
    logic [BASE_W-1:0] base;
  } entry_t;

  entry_t ent_q [LUT_N];
  entry_t ent_d [LUT_N];
  entry_t sel;

  // next state: only the addressed entry changes
  always_comb begin
    for (int i = 0; i < LUT_N; i++) begin
      ent_d[i] = ent_q[i];
    end
    if (wr_en) begin
      ent_d[wr_idx].en   = wr_data[0];
      ent_d[wr_idx].part = wr_data[PART_W:1];
      ent_d[wr_idx].base = wr_data[OUT_W-1:PAGE_LOG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LUT_N; i++) begin
        ent_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < LUT_N; i++) begin
        ent_q[i] <= ent_d[i];
      end
    end
  end

  always_comb begin
    sel     = ent_q[rd_idx];
    rd_hit  = sel.en;
    rd_addr = {sel.base, rd_page_off};
    rd_part = sel.part;
  end

endmodule

// File: rtl/aperture_xlate_direct.sv
module aperture_xlate_direct
  import aperture_xlate_pkg::*;
#(
  parameter int unsigned APER_W  = 20,
  parameter int unsigned OUT_W   = 40,
  parameter int unsigned PART_W  = 3,
  parameter int unsigned REG_LOG = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              size_we,
  input  logic              xlate_we,
  input  logic [63:0]       wr_data,
  input  logic [APER_W-1:0] lk_off,
  output logic              lk_hit,
  output logic [OUT_W-1:0]  lk_addr,
  output logic [PART_W-1:0] lk_part,
  output logic              size_err
);

  localparam logic [APER_W-1:0] REGION = {{(APER_W-1){1'b0}}, 1'b1} << REG_LOG;

  logic             en_q, en_d;
  logic             ok_q, ok_d;
  logic [5:0]       log_q, log_d;
  logic [OUT_W-1:0] xl_q, xl_d;
  logic             err_q, err_d;
  logic             reg_ce;

  logic [5:0]        log_w;
  logic [63:0]       shape_w;
  logic              shape_ok, range_ok;
  logic [APER_W-1:0] diff;
  logic [63:0]       mask64;
  logic [OUT_W-1:0]  mask;
  logic              past_lut, in_win;

  assign log_w    = wr_data[5:0];
  assign shape_w  = (64'd1 << log_w) | {58'd0, log_w};
  assign shape_ok = (wr_data == shape_w);
  assign range_ok = (log_w >= 6'(DIR_MIN_LOG)) && (log_w <= 6'(REG_LOG));
  assign reg_ce   = ctrl_we | size_we | xlate_we;

  always_comb begin
    en_d  = en_q;
    ok_d  = ok_q;
    log_d = log_q;
    xl_d  = xl_q;
    err_d = err_q;
    if (ctrl_we) en_d = wr_data[0];
    if (xlate_we) xl_d = wr_data[OUT_W-1:0];
    if (size_we) begin
      if (wr_data == 64'd0) begin
        ok_d = 1'b0;
      end else if (shape_ok && range_ok) begin
        ok_d  = 1'b1;
        log_d = log_w;
      end else begin
        ok_d  = 1'b0;
        en_d  = 1'b0;
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ok_q  <= 1'b0;
      log_q <= 6'd0;
      xl_q  <= '0;
      err_q <= 1'b0;
    end else if (reg_ce) begin
      en_q  <= en_d;
      ok_q  <= ok_d;
      log_q <= log_d;
      xl_q  <= xl_d;
      err_q <= err_d;
    end
  end

  // lookup
  assign past_lut = (lk_off >= REGION);
  assign diff     = lk_off - REGION;
  assign in_win   = ((diff >> log_q) == '0);
  assign mask64   = (64'd1 << log_q) - 64'd1;
  assign mask     = mask64[OUT_W-1:0];
  assign lk_hit   = en_q && ok_q && past_lut && in_win;
  assign lk_addr  = (xl_q & ~mask) | (OUT_W'(diff) & mask);
  assign lk_part  = xl_q[PART_W-1:0];
  assign size_err = err_q;

  AST_LOW_LOG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    size_we && (wr_data != 64'd0) && (wr_data[5:0] < 6'd12) |=> size_err && !lk_hit); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err); // R9
  AST_ZERO_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    size_we && (wr_data == 64'd0) && !size_err |=> !size_err && !lk_hit); // R10

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import aperture_xlate_pkg::*;
#(
  parameter int unsigned APER_W = 20,
  parameter int unsigned LUT_N  = 4,
  parameter int unsigned OUT_W  = 40,
  parameter int unsigned PART_W = 3,
  localparam int unsigned IDX_W   = $clog2(LUT_N),
  localparam int unsigned REG_LOG = PAGE_LOG + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [63:0]       cfg_wdata,
  output logic              cfg_err,
  input  logic              acc_valid,
  input  logic [APER_W-1:0] acc_offset,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [OUT_W-1:0]  rsp_addr,
  output logic [PART_W-1:0] rsp_part
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  cfg_kind_e kind;
  logic      lut_we, ctrl_we, size_we, xlate_we;
  assign kind     = cfg_kind_e'(cfg_kind);
  assign lut_we   = cfg_we && (kind == CFG_LUT);
  assign ctrl_we  = cfg_we && (kind == CFG_DCTRL);
  assign size_we  = cfg_we && (kind == CFG_DSIZE);
  assign xlate_we = cfg_we && (kind == CFG_DXLATE);

  logic              in_lut;
  logic              lut_hit, dir_hit;
  logic [OUT_W-1:0]  lut_addr, dir_addr;
  logic [PART_W-1:0] lut_part, dir_part;

  assign in_lut = (acc_offset[APER_W-1:REG_LOG] == '0);

  aperture_xlate_lut #(
    .LUT_N (LUT_N),
    .OUT_W (OUT_W),
    .PART_W(PART_W)
  ) u_lut (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (lut_we),
    .wr_idx     (cfg_idx),
    .wr_data    (cfg_wdata),
    .rd_idx     (acc_offset[REG_LOG-1:PAGE_LOG]),
    .rd_page_off(acc_offset[PAGE_LOG-1:0]),
    .rd_hit     (lut_hit),
    .rd_addr    (lut_addr),
    .rd_part    (lut_part)
  );

  aperture_xlate_direct #(
    .APER_W (APER_W),
    .OUT_W  (OUT_W),
    .PART_W (PART_W),
    .REG_LOG(REG_LOG)
  ) u_dir (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctrl_we (ctrl_we),
    .size_we (size_we),
    .xlate_we(xlate_we),
    .wr_data (cfg_wdata),
    .lk_off  (acc_offset),
    .lk_hit  (dir_hit),
    .lk_addr (dir_addr),
    .lk_part (dir_part),
    .size_err(cfg_err)
  );

  // response stage
  logic              vld_q, vld_d;
  logic              hit_q, hit_d;
  logic [OUT_W-1:0]  addr_q, addr_d;
  logic [PART_W-1:0] part_q, part_d;

  always_comb begin
    vld_d  = acc_valid;
    hit_d  = in_lut ? lut_hit : dir_hit;
    addr_d = '0;
    part_d = '0;
    if (hit_d) begin
      addr_d = in_lut ? lut_addr : dir_addr;
      part_d = in_lut ? lut_part : dir_part;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q  <= 1'b0;
      addr_q <= '0;
      part_q <= '0;
    end else if (acc_valid) begin
      hit_q  <= hit_d;
      addr_q <= addr_d;
      part_q <= part_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_addr  = addr_q;
  assign rsp_part  = part_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_valid |=> !rsp_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid && !rsp_hit |-> (rsp_addr == '0) && (rsp_part == '0)); // R11
  AST_PAGE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid && in_lut && lut_hit |=> rsp_hit && (rsp_addr[PAGE_LOG-1:0] == $past(acc_offset[PAGE_LOG-1:0]))); // R4

endmodule

// File: tb/aperture_xlate_bench.sv
`timescale 1ns/1ps
module aperture_xlate_bench;

  localparam int APER_W  = 20;
  localparam int LUT_N   = 4;
  localparam int OUT_W   = 40;
  localparam int PART_W  = 3;
  localparam int REG_LOG = 18;
  localparam logic [63:0] REGION   = 64'd1 << REG_LOG;
  localparam logic [63:0] OUT_MASK = (64'd1 << OUT_W) - 64'd1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_kind;
  logic [1:0]        cfg_idx;
  logic [63:0]       cfg_wdata;
  logic              cfg_err;
  logic              acc_valid;
  logic [APER_W-1:0] acc_offset;
  logic              rsp_valid, rsp_hit;
  logic [OUT_W-1:0]  rsp_addr;
  logic [PART_W-1:0] rsp_part;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model state
  bit          m_len [LUT_N];
  logic [2:0]  m_lpart [LUT_N];
  logic [63:0] m_lbase [LUT_N];
  bit          m_den, m_dok, m_err;
  int          m_dlog;
  logic [63:0] m_xl;

  always #10 clk = ~clk;

  aperture_xlate #(
    .APER_W(APER_W), .LUT_N(LUT_N), .OUT_W(OUT_W), .PART_W(PART_W)
  ) u_aperture_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
    .acc_valid(acc_valid), .acc_offset(acc_offset), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_part(rsp_part)
  );

  task automatic cfg_write(input logic [1:0] kind, input int idx, input logic [63:0] data);
    int l;
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx[1:0]; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (kind)
      2'd0: begin
        m_len[idx]   = data[0];
        m_lpart[idx] = data[3:1];
        m_lbase[idx] = data & OUT_MASK & ~64'hFFFF;
      end
      2'd1: m_den = data[0];
      2'd2: begin
        l = int'(data[5:0]);
        if (data == 64'd0) m_dok = 1'b0;
        else if ((data == ((64'd1 << l) | 64'(l))) && l >= 12 && l <= REG_LOG) begin
          m_dok = 1'b1; m_dlog = l;
        end else begin
          m_dok = 1'b0; m_den = 1'b0; m_err = 1'b1;
        end
      end
      default: m_xl = data & OUT_MASK;
    endcase
  endtask

  task automatic probe(input logic [63:0] off, input string req);
    logic        e_hit;
    logic [63:0] e_addr, d, msk;
    logic [2:0]  e_part;
    int          i;
    e_hit = 1'b0; e_addr = 64'd0; e_part = 3'd0;
    if (off < REGION) begin
      i = int'(off >> 16);
      if (m_len[i]) begin
        e_hit = 1'b1; e_addr = m_lbase[i] | (off & 64'hFFFF); e_part = m_lpart[i];
      end
    end else begin
      d = off - REGION;
      if (m_den && m_dok && (d < (64'd1 << m_dlog))) begin
        msk = (64'd1 << m_dlog) - 64'd1;
        e_hit = 1'b1; e_addr = (m_xl & ~msk) | d; e_part = m_xl[2:0];
      end
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_offset = off[APER_W-1:0];
    @(negedge clk);
    acc_valid = 1'b0;
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_addr !== e_addr[OUT_W-1:0] || rsp_part !== e_part) begin
      n_bad++;
      $display("FAIL %s off=%h got v=%b h=%b a=%h p=%0d exp v=1 h=%b a=%h p=%0d",
               req, off, rsp_valid, rsp_hit, rsp_addr, rsp_part, e_hit, e_addr[OUT_W-1:0], e_part);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %b exp %b", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 256; k++) begin
      probe(64'(k) * 64'd4096 + ((64'(k) * 64'd37) & 64'hFFF), req);
    end
    probe(REGION - 64'd1, req);
    probe(REGION, req);
    if (m_dok) begin
      probe(REGION + (64'd1 << m_dlog) - 64'd1, req);
      probe(REGION + (64'd1 << m_dlog), req);
    end
  endtask

  function automatic logic [63:0] size_word(input int l);
    return (64'd1 << l) | 64'(l);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 2'd0; cfg_idx = 2'd0; cfg_wdata = 64'd0;
    acc_valid = 1'b0; acc_offset = '0;
    for (int i = 0; i < LUT_N; i++) begin
      m_len[i] = 1'b0; m_lpart[i] = 3'd0; m_lbase[i] = 64'd0;
    end
    m_den = 1'b0; m_dok = 1'b0; m_err = 1'b0; m_dlog = 0; m_xl = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_bit(rsp_valid, 1'b0, "R1 rsp_valid");
    check_bit(cfg_err, 1'b0, "R1 cfg_err");
    sweep("R1");
    // R2: no response without request
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R2 idle");

    // R3 R4 R5: table entries, entry 2 disabled, junk in ignored bits
    for (int i = 0; i < LUT_N; i++) begin
      cfg_write(2'd0, i, 64'hF000_0000_0000_0000 | (64'h00A5_0000_0000 ^ (64'(i) << 24) ^ (64'(i) << 16))
                          | 64'h5A50 | (64'(i + 1) << 1) | ((i != 2) ? 64'd1 : 64'd0));
    end
    sweep("R3 R4 R5");

    // R6 R7 R8: every legal direct size
    cfg_write(2'd3, 0, 64'h003C_8765_4000 | 64'd5);
    cfg_write(2'd1, 0, 64'd1);
    for (int l = 12; l <= REG_LOG; l++) begin
      cfg_write(2'd2, 0, size_word(l));
      check_bit(cfg_err, 1'b0, "R8 legal size");
      sweep("R6 R8 R11");
    end

    // R7: disable
    cfg_write(2'd1, 0, 64'd0);
    sweep("R7");
    cfg_write(2'd1, 0, 64'd1);
    probe(REGION + 64'h123, "R7 reenable");

    // R10: zero size clears quietly
    cfg_write(2'd2, 0, 64'd0);
    check_bit(cfg_err, 1'b0, "R10 no err");
    probe(REGION + 64'h123, "R10");
    cfg_write(2'd2, 0, size_word(16));
    probe(REGION + 64'h123, "R10 restore");

    // R9: undersized rejection
    cfg_write(2'd2, 0, size_word(11));
    check_bit(cfg_err, 1'b1, "R9 low log");
    probe(REGION + 64'h123, "R9 window shut");
    cfg_write(2'd2, 0, size_word(14));
    probe(REGION + 64'h123, "R9 still disabled");
    cfg_write(2'd1, 0, 64'd1);
    probe(REGION + 64'h123, "R9 reenabled");
    // R8 R9: above cap, and malformed shapes
    cfg_write(2'd2, 0, size_word(REG_LOG + 1));
    check_bit(cfg_err, 1'b1, "R9 cap");
    probe(REGION + 64'h123, "R8 cap shut");
    cfg_write(2'd1, 0, 64'd1);
    cfg_write(2'd2, 0, size_word(14) | (64'd1 << 13));
    probe(REGION + 64'h123, "R9 non power");
    cfg_write(2'd1, 0, 64'd1);
    cfg_write(2'd2, 0, (64'd1 << 15) | 64'd14);
    probe(REGION + 64'h123, "R9 log mismatch");
    check_bit(cfg_err, 1'b1, "R9 sticky");
    cfg_write(2'd2, 0, size_word(REG_LOG));
    cfg_write(2'd1, 0, 64'd1);
    sweep("R6 R9 R11 final");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule